// File: doc/BRIEF.md
# Windowed Deadman Timer with Two-Key Clear

This block is a bus-mapped deadman timer. Once software sets its enable bit, a counter advances by one on every clock. Software must restart the counter before it reaches a programmed limit. A restart takes two writes in a fixed order. The first write arms the sequence with a pre-clear key. The second write delivers the clear key, and it is accepted only while the clear window is open. The window opens when the counter reaches a programmed opening point and closes at the limit.

Several conditions raise a deadman event: the counter reaching the limit, a wrong first key, or a second key that is wrong, unarmed or outside the window. Each of these sets a sticky status flag. The event drives a reset request and a cause vector with bit 5 set, which a separate reset controller latches. Status flags stay set until reset. The bus has an address, write data, a write strobe and combinational read data.

Top module: `deadman_timer`

## Requirements
- R1: After reset the timer is disabled, the counter (0x40) reads 0, the status word (0x30) reads 0, the limit (0x60) and opening point (0x70) read their default parameter values, and reset_req and cause are 0.
- R2: Control bit 15 (offset 0x00) is the enable. While it is set and no event is pending, the counter grows by exactly one per clock. While it is clear, the counter reads 0.
- R3: Status bit 0 is high exactly when the timer is enabled, no event is pending, and the counter is at least the opening point and below the limit.
- R4: A write to offset 0x10 while enabled arms the sequence when bits 15:8 equal 0x40. Any other value sets status bit 7 and raises the event.
- R5: A write to offset 0x20 with bits 7:0 equal to 0x08, made while armed and while the window is open, returns the counter to 0, disarms the sequence and sets no flag.
- R6: A write to offset 0x20 while enabled sets status bit 6 and raises the event if the sequence is not armed, if the window is closed, or if the key is not 0x08.
- R7: When the counter equals the limit while enabled with no event pending, status bit 5 is set and the counter then stays at the limit.
- R8: A raised event sets status bit 5, drives reset_req high and sets cause to 0x20 (bit 5 only). All of these hold until reset.
- R9: In the clock right after a write that clears a set enable bit, any write has no effect and the read data is 0.
- R10: The limit and the opening point accept writes only while the timer is disabled. Writes to them while enabled leave them unchanged.
- R11: Key writes (0x10, 0x20) made while the timer is disabled change no flag and raise no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| reset_req | output | 1 | Sticky deadman reset request |
| cause | output | 8 | Reset-cause vector for the reset controller; bit 5 marks a deadman event |

## Verification
The bench builds the timer with a 16-bit counter, a default limit of 40 and a default opening point of 24. At run time it reprograms these to a limit of 20 and an opening point of 10. These small values let every corner be reached in a few dozen clocks: the window opening and closing, an in-window restart, a key sent before the window opens, and a full expiry with the counter frozen at its limit. After each event the bench applies a reset and then confirms that the default values return.

// File: rtl/dmt_pkg.sv
// Package: shared offsets, key values and status bit positions for the
// deadman timer. Assumes byte offsets fit in the bus address width.
package dmt_pkg;
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_ARM   = 8'h10;
    localparam logic [7:0] OFS_KICK  = 8'h20;
    localparam logic [7:0] OFS_STAT  = 8'h30;
    localparam logic [7:0] OFS_COUNT = 8'h40;
    localparam logic [7:0] OFS_LIMIT = 8'h60;
    localparam logic [7:0] OFS_OPEN  = 8'h70;

    localparam int EN_BIT     = 15;
    localparam int ARM_LSB    = 8;
    localparam int STAT_WIN   = 0;
    localparam int STAT_EVT   = 5;
    localparam int STAT_BAD2  = 6;
    localparam int STAT_BAD1  = 7;
    localparam int CAUSE_BIT  = 5;

    localparam logic [7:0] ARM_KEY  = 8'h40;
    localparam logic [7:0] KICK_KEY = 8'h08;

    typedef struct packed {
        logic bad1;
        logic bad2;
        logic evt;
        logic win;
    } dmt_flags_t;
endpackage

// File: rtl/dmt_regbank.sv
// Register bank: decodes bus writes, holds the enable, limit and opening
// point, produces key strobes and the read mux. Assumes one access per clock
// and that software keeps the opening point at or below the limit.
module dmt_regbank
    import dmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter logic [CNT_W-1:0] LIMIT_RST = CNT_W'(1000),
    parameter logic [CNT_W-1:0] OPEN_RST  = CNT_W'(500)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic [CNT_W-1:0]  cnt,
    input  dmt_flags_t        flags,
    output logic              en,
    output logic              quiet,
    output logic [CNT_W-1:0]  limit,
    output logic [CNT_W-1:0]  open_at,
    output logic              arm_stb,
    output logic              kick_stb,
    output logic [DATA_W-1:0] rdata
);
    logic acc;
    logic hit_ctrl, hit_arm, hit_kick, hit_limit, hit_open;

    // Decode: a write is honoured unless it falls in the quiet cycle.
    assign acc       = we && !quiet;
    assign hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
    assign hit_arm   = (addr == ADDR_W'(OFS_ARM));
    assign hit_kick  = (addr == ADDR_W'(OFS_KICK));
    assign hit_limit = (addr == ADDR_W'(OFS_LIMIT));
    assign hit_open  = (addr == ADDR_W'(OFS_OPEN));

    // Key strobes: only while enabled.
    assign arm_stb  = acc && en && hit_arm;
    assign kick_stb = acc && en && hit_kick;

    // Enable bit and the one-cycle quiet flag after a disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            quiet <= 1'b0;
        end else begin
            quiet <= acc && hit_ctrl && en && !wdata[EN_BIT];
            if (acc && hit_ctrl) en <= wdata[EN_BIT];
        end
    end

    // Limit and opening point, writable only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit   <= LIMIT_RST;
            open_at <= OPEN_RST;
        end else if (acc && !en) begin
            if (hit_limit) limit   <= wdata[CNT_W-1:0];
            if (hit_open)  open_at <= wdata[CNT_W-1:0];
        end
    end

    // Read mux; zero during the quiet cycle.
    always_comb begin
        rdata = '0;
        if (!quiet) begin
            unique case (1'b1)
                hit_ctrl:  rdata[EN_BIT] = en;
                (addr == ADDR_W'(OFS_STAT)): begin
                    rdata[STAT_WIN]  = flags.win;
                    rdata[STAT_EVT]  = flags.evt;
                    rdata[STAT_BAD2] = flags.bad2;
                    rdata[STAT_BAD1] = flags.bad1;
                end
                (addr == ADDR_W'(OFS_COUNT)): rdata = DATA_W'(cnt);
                hit_limit: rdata = DATA_W'(limit);
                hit_open:  rdata = DATA_W'(open_at);
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dmt_counter.sv
// Counter: advances while enabled and no event is pending, clears on a good
// key sequence, holds at the limit. Derives the clear window and the expiry.
// Assumes the limit and opening point are stable while enabled.
module dmt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             evt,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] open_at,
    output logic [CNT_W-1:0] cnt,
    output logic             win,
    output logic             expire
);
    logic at_limit;

    // Window and expiry decode from the current count.
    assign at_limit = (cnt == limit);
    assign win      = en && !evt && (cnt >= open_at) && (cnt < limit);
    assign expire   = en && !evt && !clr && at_limit;

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (!evt && !at_limit) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/dmt_keyseq.sv
// Key sequencer: tracks the armed state and checks both keys. Emits a good
// clear pulse, a fault pulse and the two sticky bad-key flags. Assumes the
// strobes are already gated by the enable.
module dmt_keyseq
    import dmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       win,
    input  logic       arm_stb,
    input  logic       kick_stb,
    input  logic [7:0] arm_key,
    input  logic [7:0] kick_key,
    output logic       kick_ok,
    output logic       key_fault,
    output logic       bad1,
    output logic       bad2
);
    logic armed;
    logic arm_ok, arm_bad, kick_bad;

    // Key comparison.
    assign arm_ok    = arm_stb && (arm_key == ARM_KEY);
    assign arm_bad   = arm_stb && (arm_key != ARM_KEY);
    assign kick_ok   = kick_stb && armed && win && (kick_key == KICK_KEY);
    assign kick_bad  = kick_stb && !kick_ok;
    assign key_fault = arm_bad || kick_bad;

    // Armed state between the two steps.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)   armed <= 1'b0;
        else if (kick_stb)   armed <= 1'b0;
        else if (arm_ok)     armed <= 1'b1;
        else if (arm_bad)    armed <= 1'b0;
    end

    // Sticky bad-key flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad1 <= 1'b0;
            bad2 <= 1'b0;
        end else begin
            if (arm_bad)  bad1 <= 1'b1;
            if (kick_bad) bad2 <= 1'b1;
        end
    end
endmodule

// File: rtl/deadman_timer.sv
// Deadman timer top: joins the register bank, counter and key sequencer,
// holds the sticky event and drives the reset request and cause vector.
// Assumes a single clock domain and a synchronous active-low reset.
module deadman_timer
    import dmt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter logic [CNT_W-1:0] LIMIT_RST = CNT_W'(1000),
    parameter logic [CNT_W-1:0] OPEN_RST  = CNT_W'(500)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              reset_req,
    output logic [7:0]        cause
);
    logic             en_q, quiet_q, arm_stb, kick_stb;
    logic [CNT_W-1:0] limit_q, open_q, cnt_q;
    logic             win, expire, kick_ok, key_fault, bad1, bad2, evt_q;
    dmt_flags_t       flags;

    assign flags = '{bad1: bad1, bad2: bad2, evt: evt_q, win: win};

    dmt_regbank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .LIMIT_RST(LIMIT_RST), .OPEN_RST(OPEN_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
        .we(bus_we), .cnt(cnt_q), .flags(flags), .en(en_q), .quiet(quiet_q),
        .limit(limit_q), .open_at(open_q), .arm_stb(arm_stb),
        .kick_stb(kick_stb), .rdata(bus_rdata)
    );

    dmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en_q), .evt(evt_q), .clr(kick_ok),
        .limit(limit_q), .open_at(open_q), .cnt(cnt_q), .win(win),
        .expire(expire)
    );

    dmt_keyseq u_keys (
        .clk(clk), .rst_n(rst_n), .en(en_q), .win(win), .arm_stb(arm_stb),
        .kick_stb(kick_stb), .arm_key(bus_wdata[ARM_LSB +: 8]),
        .kick_key(bus_wdata[7:0]), .kick_ok(kick_ok), .key_fault(key_fault),
        .bad1(bad1), .bad2(bad2)
    );

    // Sticky deadman event from expiry or any key fault.
    always_ff @(posedge clk) begin
        if (!rst_n)                     evt_q <= 1'b0;
        else if (expire || key_fault)   evt_q <= 1'b1;
    end

    // Outputs toward the reset controller.
    always_comb begin
        cause            = '0;
        cause[CAUSE_BIT] = evt_q;
        reset_req        = evt_q;
    end
endmodule

// File: rtl/dmt_checker.sv
// Checker: temporal properties of the deadman timer, bound into the top.
// Assumes the internal names of deadman_timer.
module dmt_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             evt,
    input logic             quiet,
    input logic             kick_ok,
    input logic             reset_req,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] limit,
    input logic [CNT_W-1:0] open_at
);
    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req); // R8
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !evt && !kick_ok && cnt != limit) |=> ((cnt - $past(cnt)) == CNT_W'(1))); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0)); // R2
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        kick_ok |=> (cnt == '0)); // R5
    AST_EXPIRE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !evt && !kick_ok && cnt == limit) |=> evt); // R7
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> !en); // R9
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> ($stable(limit) && $stable(open_at))); // R10
endmodule

bind deadman_timer dmt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .evt(evt_q), .quiet(quiet_q),
    .kick_ok(kick_ok), .reset_req(reset_req), .cnt(cnt_q), .limit(limit_q),
    .open_at(open_q)
);

// File: tb/tb_deadman_timer.sv
module tb_deadman_timer;
    localparam int CLK_P = 10;
    localparam int CW = 16;
    localparam int LIM0 = 40;
    localparam int OPN0 = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        reset_req;
    logic [7:0]  cause;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    deadman_timer #(.ADDR_W(8), .DATA_W(32), .CNT_W(CW),
        .LIMIT_RST(16'(LIM0)), .OPEN_RST(16'(OPN0))) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .reset_req(reset_req),
        .cause(cause));

    always #(CLK_P/2) clk = ~clk;

    // Reference model state
    int m_en, m_cnt, m_lim, m_opn, m_q, m_arm, m_b1, m_b2, m_evt;
    int n_en, n_cnt, n_lim, n_opn, n_q, n_arm, n_b1, n_b2, n_evt;
    int w, acc, kick;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] r = 0;
        int wn;
        if (m_q != 0) return 0;
        wn = (m_en != 0 && m_evt == 0 && m_cnt >= m_opn && m_cnt < m_lim);
        case (a)
            8'h00: r[15] = (m_en != 0);
            8'h30: begin
                r[0] = wn[0]; r[5] = (m_evt != 0);
                r[6] = (m_b2 != 0); r[7] = (m_b1 != 0);
            end
            8'h40: r = 32'(m_cnt);
            8'h60: r = 32'(m_lim);
            8'h70: r = 32'(m_opn);
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (m_q != 0) return "R9";
        case (a)
            8'h30: return "R3";
            8'h60, 8'h70: return "R10";
            default: return "R2";
        endcase
    endfunction

    // Behavioural model step at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_cnt = 0; m_lim = LIM0; m_opn = OPN0; m_q = 0;
            m_arm = 0; m_b1 = 0; m_b2 = 0; m_evt = 0;
        end else begin
            w = (m_en != 0 && m_evt == 0 && m_cnt >= m_opn && m_cnt < m_lim);
            acc = (bus_we && m_q == 0);
            kick = 0;
            n_en = m_en; n_cnt = m_cnt; n_lim = m_lim; n_opn = m_opn; n_q = 0;
            n_arm = m_arm; n_b1 = m_b1; n_b2 = m_b2; n_evt = m_evt;
            if (acc && m_en != 0 && bus_addr == 8'h10) begin
                if (bus_wdata[15:8] == 8'h40) n_arm = 1;
                else begin n_arm = 0; n_b1 = 1; n_evt = 1; end
            end
            if (acc && m_en != 0 && bus_addr == 8'h20) begin
                if (m_arm != 0 && w != 0 && bus_wdata[7:0] == 8'h08) kick = 1;
                else begin n_b2 = 1; n_evt = 1; end
                n_arm = 0;
            end
            if (m_en == 0) begin n_cnt = 0; n_arm = 0; end
            else if (kick != 0) n_cnt = 0;
            else if (m_evt == 0) begin
                if (m_cnt == m_lim) n_evt = 1;
                else n_cnt = m_cnt + 1;
            end
            if (acc && bus_addr == 8'h00) begin
                if (m_en != 0 && !bus_wdata[15]) n_q = 1;
                n_en = bus_wdata[15];
            end
            if (acc && m_en == 0 && bus_addr == 8'h60) n_lim = int'(bus_wdata[15:0]);
            if (acc && m_en == 0 && bus_addr == 8'h70) n_opn = int'(bus_wdata[15:0]);
            m_en = n_en; m_cnt = n_cnt; m_lim = n_lim; m_opn = n_opn; m_q = n_q;
            m_arm = n_arm; m_b1 = n_b1; m_b2 = n_b2; m_evt = n_evt;
        end
    end

    // Per-cycle comparison, a quarter period after the falling edge
    always @(negedge clk) begin
        #(CLK_P/4);
        if (rst_n) begin
            check(reset_req == (m_evt != 0), "R8 reset_req", 32'(reset_req), 32'(m_evt != 0));
            check(cause == ((m_evt != 0) ? 8'h20 : 8'h00), "R8 cause", 32'(cause),
                  (m_evt != 0) ? 32'h20 : 32'h0);
            check(bus_rdata == model_read(bus_addr), tag_of(bus_addr), bus_rdata,
                  model_read(bus_addr));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic wr2(input logic [7:0] a1, input logic [31:0] d1,
                       input logic [7:0] a2, input logic [31:0] d2);
        @(negedge clk); bus_addr = a1; bus_wdata = d1; bus_we = 1'b1;
        @(negedge clk); bus_addr = a2; bus_wdata = d2;
        #(CLK_P/4);
        check(bus_rdata == 32'h0, "R9 quiet read", bus_rdata, 32'h0);
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); bus_addr = a; bus_we = 1'b0;
        #(CLK_P/4); v = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; bus_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic setup_run();
        wr(8'h70, 32'd10);
        wr(8'h60, 32'd20);
        wr(8'h00, 32'h8000);
    endtask

    task automatic wait_window();
        logic [31:0] v;
        for (int i = 0; i < 100; i++) begin
            rd(8'h30, v);
            if (v[0]) break;
        end
    endtask

    initial begin
        logic [31:0] v, a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h30, v); check(v == 0, "R1 status", v, 0);
        rd(8'h40, v); check(v == 0, "R1 count", v, 0);
        rd(8'h60, v); check(v == LIM0, "R1 limit", v, LIM0);
        rd(8'h70, v); check(v == OPN0, "R1 open", v, OPN0);
        check(reset_req == 0 && cause == 0, "R1 outputs", {reset_req, cause}, 0);

        // R10 writes while disabled take effect; R2 counting
        setup_run();
        rd(8'h60, v); check(v == 20, "R10 limit write", v, 20);
        rd(8'h40, a); repeat (4) @(negedge clk); rd(8'h40, b);
        check(b - a == 5, "R2 count step", b - a, 5);
        rd(8'h00, v); check(v[15] == 1'b1, "R2 enable bit", v, 32'h8000);

        // R3 window, R4 and R5 good sequence
        wait_window();
        rd(8'h40, v); check(v >= 10 && v < 20, "R3 window range", v, 10);
        wr(8'h10, 32'h4000);
        wr(8'h20, 32'h08);
        rd(8'h40, v); check(v < 4, "R5 counter restarted", v, 0);
        rd(8'h30, v); check(v == 0, "R5 no flags, R3 window closed", v, 0);

        // R10 write while enabled ignored
        wr(8'h60, 32'd99);
        rd(8'h60, v); check(v == 20, "R10 limit frozen", v, 20);

        // R9 write in quiet cycle dropped
        wr2(8'h00, 32'h0, 8'h70, 32'd5);
        rd(8'h70, v); check(v == 10, "R9 dropped write", v, 10);
        rd(8'h00, v); check(v[15] == 1'b0, "R2 disabled", v, 0);
        rd(8'h40, v); check(v == 0, "R2 zero when disabled", v, 0);

        // R11 keys while disabled ignored
        wr(8'h10, 32'h3300);
        wr(8'h20, 32'h55);
        rd(8'h30, v); check(v == 0, "R11 no flags", v, 0);
        check(reset_req == 0, "R11 no event", 32'(reset_req), 0);

        // R4 bad first key, R8 sticky
        wr(8'h00, 32'h8000);
        wr(8'h10, 32'h3300);
        rd(8'h30, v); check(v[7] && v[5] && !v[6], "R4 bad first key", v, 32'hA0);
        repeat (30) @(negedge clk);
        #(CLK_P/4);
        check(reset_req && cause == 8'h20, "R8 sticky", {reset_req, cause}, 9'h120);
        do_reset();
        rd(8'h60, v); check(v == LIM0, "R1 limit after reset", v, LIM0);

        // R6 second key without first
        setup_run(); wait_window();
        wr(8'h20, 32'h08);
        rd(8'h30, v); check(v[6] && v[5] && !v[7], "R6 unarmed", v, 32'h60);
        do_reset();

        // R6 second key with window closed
        setup_run();
        wr(8'h10, 32'h4000);
        wr(8'h20, 32'h08);
        rd(8'h30, v); check(v[6] && v[5] && !v[7], "R6 window closed", v, 32'h60);
        do_reset();

        // R6 wrong second key
        setup_run(); wait_window();
        wr(8'h10, 32'h4000);
        wr(8'h20, 32'h09);
        rd(8'h30, v); check(v[6] && v[5], "R6 wrong key", v, 32'h60);
        do_reset();

        // R7 expiry
        setup_run();
        repeat (40) @(negedge clk);
        rd(8'h40, v); check(v == 20, "R7 count held at limit", v, 20);
        rd(8'h30, v); check(v == 32'h20, "R7 event only", v, 32'h20);
        check(reset_req == 1'b1, "R7 reset request", 32'(reset_req), 1);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule